// File: doc/BRIEF.md
# Page Access Permission Checker with Fault Recording

This block sits at the end of a page-table walk. It takes the leaf entry that the walker found and decides whether the current access may use it. The inputs are the entry's 3-bit permission code, its referenced and modified bits, the kind of access (read, write, instruction fetch) and the privilege of the requester. The block returns a fault code, the rights that may be cached for the page, and a request to write the entry back with updated referenced and modified bits.

The block also keeps a fault status register and a fault address register. Each recorded fault leaves its access index, fault code and a valid mark in the status register and its virtual address in the address register. If an earlier fault was never read, the status register is first reduced to an overflow mark. A no-fault mode lets user accesses through without faulting. Recorded faults are turned into one-cycle instruction-fault or data-fault pulses toward the core, unless no-fault mode is on or traps are disabled.

Top module: `pte_access_guard`

## Requirements
- R1: A user access (req_super=0) to an entry with permission code 6 or 7 gets fault code 12 (privilege error), whatever its kind.
- R2: Otherwise fault code 8 (protection error) is given when a needed right is absent. A write needs W, a fetch needs X, a plain read needs R, and a write-fetch needs both W and X. W is present for codes 1 and 3, and for codes 5 and 7 when supervisor. X is present for codes 2, 3 and 4, and for codes 6 and 7 when supervisor. R is present for every code except 4. Fault code 0 means allowed.
- R3: When nofault_mode=1, user accesses never fault. Their fault code is 0, status, address and trap outputs are untouched, and they complete as allowed. Supervisor faults are still recorded.
- R4: On an allowed access, wb_ref=1 and wb_mod = old modified bit OR write. wb_req=1 only when the referenced bit was clear, or when a write finds the modified bit clear. A faulting access gives wb_req=0.
- R5: Granted rights {X,W,R} (bit 2..0) follow the privilege table. A user gets R on codes 0-3 and 5, W on codes 1 and 3, X on codes 2-4, and nothing on codes 6 and 7. A supervisor gets R on all codes but 4, W on 1, 3, 5 and 7, and X on 2, 3, 4, 6 and 7. A faulting access gets no rights.
- R6: W is removed from the granted rights whenever the updated modified bit is 0.
- R7: A recorded fault writes the status register as fsr = ovf | (index << 5) | code | 2 and loads far with req_va. The index is {write, fetch, super} in bits 2..0.
- R8: If the status register (after any same-cycle read clear) is non-zero when a fault is recorded, bit 0 of the new value is 1 and the older contents are discarded.
- R9: A recorded fault pulses ifault for a fetch or dfault for any other access for one cycle, only when nofault_mode=0 and traps_on=1.
- R10: fsr_rd=1 clears the status register. If a fault is recorded in the same cycle, the fault is written onto a cleared register, with no overflow.
- R11: After reset every output is 0.
- R12: All results appear one clock after the request is sampled. Without req_valid, rsp_valid, the fault code, rights, write-back and trap outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access to check this cycle |
| req_perm | input | 3 | Permission code of the leaf entry |
| req_ref | input | 1 | Entry referenced bit |
| req_mod | input | 1 | Entry modified bit |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_super | input | 1 | Access is privileged |
| req_va | input | VA_W | Virtual address of the access |
| nofault_mode | input | 1 | Suppress faults of user accesses |
| traps_on | input | 1 | Traps enabled in the core |
| fsr_rd | input | 1 | Status register is being read (clears it) |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_fault_code | output | 4 | 0 allowed, 8 protection, 12 privilege |
| rsp_rights | output | 3 | Granted rights {X,W,R} |
| wb_req | output | 1 | Entry must be written back |
| wb_ref | output | 1 | Referenced bit to write |
| wb_mod | output | 1 | Modified bit to write |
| ifault | output | 1 | Instruction fault pulse |
| dfault | output | 1 | Data fault pulse |
| fsr | output | 8 | Fault status register |
| far | output | VA_W | Fault address register |

## Verification
Every result is registered once, so the fault code, rights, write-back fields, trap pulses and both registers are due on the first clock edge after the request or read is sampled. The bench drives on the falling edge and computes the expected values for that edge from its own model. It compares all outputs on the next falling edge, every cycle. Directed cases follow a single request with a check one cycle later. Overflow and read-clear ordering are checked through sequences of faults and reads.

// File: rtl/pag_pkg.sv
// Package: shared codes and helpers for the page access checker.
// Assumes rights are packed {X,W,R} and fault codes are already shifted into bits 3..2.
package pag_pkg;
    typedef enum logic [3:0] {
        FLT_NONE = 4'd0,
        FLT_PROT = 4'd8,
        FLT_PRIV = 4'd12
    } fault_code_t;

    localparam int RIGHT_R = 0;
    localparam int RIGHT_W = 1;
    localparam int RIGHT_X = 2;
    localparam int FSR_W   = 8;

    // Access index: write in bit 2, fetch in bit 1, privilege in bit 0
    function automatic logic [2:0] acc_index(input logic wr, input logic fe, input logic sup);
        return {wr, fe, sup};
    endfunction
endpackage

// File: rtl/pag_perm_check.sv
// Module: decodes the permission code for one privilege level and judges the access.
// Purely combinational; assumes exactly one leaf entry per request.
module pag_perm_check
    import pag_pkg::*;
#(
    parameter int CODES = 8
) (
    input  logic [2:0] perm,
    input  logic       is_write,
    input  logic       is_fetch,
    input  logic       is_super,
    output logic [3:0] err_code,
    output logic [2:0] rights_raw
);
    logic [CODES-1:0] rd_ok;
    logic [CODES-1:0] wr_ok;
    logic [CODES-1:0] ex_ok;

    // One decode slice per permission code
    for (genvar c = 0; c < CODES; c++) begin : g_code
        localparam logic [2:0] C = 3'(c);
        assign rd_ok[c] = (C != 3'd4) && (is_super || (C < 3'd6));
        assign wr_ok[c] = (C == 3'd1) || (C == 3'd3) ||
                          (is_super && ((C == 3'd5) || (C == 3'd7)));
        assign ex_ok[c] = (C == 3'd2) || (C == 3'd3) || (C == 3'd4) ||
                          (is_super && ((C == 3'd6) || (C == 3'd7)));
    end

    logic priv_err;
    logic denied;

    // Judge the access: privilege first, then the missing right
    always_comb begin
        priv_err = !is_super && perm[2] && perm[1];
        denied   = (is_write && !wr_ok[perm]) ||
                   (is_fetch && !ex_ok[perm]) ||
                   (!is_write && !is_fetch && !rd_ok[perm]);
        if (priv_err)    err_code = FLT_PRIV;
        else if (denied) err_code = FLT_PROT;
        else             err_code = FLT_NONE;
        rights_raw = {ex_ok[perm], wr_ok[perm], rd_ok[perm]};
    end
endmodule

// File: rtl/pag_ref_mod.sv
// Module: computes the updated referenced/modified bits and whether a write-back is due.
// Combinational; assumes the caller gates it with "access allowed".
module pag_ref_mod (
    input  logic old_ref,
    input  logic old_mod,
    input  logic is_write,
    output logic new_ref,
    output logic new_mod,
    output logic changed
);
    // Set referenced always, modified on a write; flag any change
    always_comb begin
        new_ref = 1'b1;
        new_mod = old_mod | is_write;
        changed = !old_ref || (is_write && !old_mod);
    end
endmodule

// File: rtl/pag_fault_regs.sv
// Module: fault status and fault address registers with overflow marking and read-clear.
// Assumes rec is asserted for at most one fault per cycle.
module pag_fault_regs
    import pag_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec,
    input  logic [2:0]       idx,
    input  logic [3:0]       code,
    input  logic [VA_W-1:0]  va,
    input  logic             rd,
    output logic [FSR_W-1:0] fsr_q,
    output logic [VA_W-1:0]  far_q
);
    logic [FSR_W-1:0] base;
    logic [FSR_W-1:0] fsr_next;

    // Build the next status value from the read-cleared base
    always_comb begin
        base     = rd ? '0 : fsr_q;
        fsr_next = {{(FSR_W-1){1'b0}}, (base != '0)} |
                   {idx, 5'b0} | {4'b0, code} | 8'h02;
    end

    // Hold status and address; fault capture outranks the clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsr_q <= '0;
            far_q <= '0;
        end else if (rec) begin
            fsr_q <= fsr_next;
            far_q <= va;
        end else if (rd) begin
            fsr_q <= '0;
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rec && !rd && fsr_q != '0) |=> fsr_q[0]);
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !rec) |=> fsr_q == '0);
    p_fresh_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && rec) |=> !fsr_q[0] && fsr_q[1]);
endmodule

// File: rtl/pte_access_guard.sv
// Module: top of the page access checker. Judges a leaf entry against an access,
// yields fault code, rights and write-back, records faults and raises trap pulses.
// Assumes one request per cycle; every result is registered once.
module pte_access_guard
    import pag_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_perm,
    input  logic            req_ref,
    input  logic            req_mod,
    input  logic            req_write,
    input  logic            req_fetch,
    input  logic            req_super,
    input  logic [VA_W-1:0] req_va,
    input  logic            nofault_mode,
    input  logic            traps_on,
    input  logic            fsr_rd,
    output logic            rsp_valid,
    output logic [3:0]      rsp_fault_code,
    output logic [2:0]      rsp_rights,
    output logic            wb_req,
    output logic            wb_ref,
    output logic            wb_mod,
    output logic            ifault,
    output logic            dfault,
    output logic [7:0]      fsr,
    output logic [VA_W-1:0] far
);
    logic [3:0] err_code;
    logic [2:0] rights_raw;
    logic       new_ref, new_mod, changed;

    pag_perm_check #(.CODES(8)) u_perm (
        .perm      (req_perm),
        .is_write  (req_write),
        .is_fetch  (req_fetch),
        .is_super  (req_super),
        .err_code  (err_code),
        .rights_raw(rights_raw)
    );

    pag_ref_mod u_refmod (
        .old_ref (req_ref),
        .old_mod (req_mod),
        .is_write(req_write),
        .new_ref (new_ref),
        .new_mod (new_mod),
        .changed (changed)
    );

    logic       fault_rec;
    logic       grant;
    logic       trap_go;
    logic [2:0] rights_eff;

    // Decide recorded fault, grant, trap and effective rights
    always_comb begin
        fault_rec  = req_valid && (err_code != FLT_NONE) && !(nofault_mode && !req_super);
        grant      = req_valid && !fault_rec;
        trap_go    = fault_rec && !nofault_mode && traps_on;
        rights_eff = rights_raw;
        if (!new_mod) rights_eff[RIGHT_W] = 1'b0;
    end

    pag_fault_regs #(.VA_W(VA_W)) u_fregs (
        .clk  (clk),
        .rst_n(rst_n),
        .rec  (fault_rec),
        .idx  (acc_index(req_write, req_fetch, req_super)),
        .code (err_code),
        .va   (req_va),
        .rd   (fsr_rd),
        .fsr_q(fsr),
        .far_q(far)
    );

    // Register the per-request results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_fault_code <= '0;
            rsp_rights     <= '0;
            wb_req         <= 1'b0;
            wb_ref         <= 1'b0;
            wb_mod         <= 1'b0;
            ifault         <= 1'b0;
            dfault         <= 1'b0;
        end else begin
            rsp_valid      <= req_valid;
            rsp_fault_code <= fault_rec ? err_code : 4'd0;
            rsp_rights     <= grant ? rights_eff : 3'd0;
            wb_req         <= grant && changed;
            wb_ref         <= grant && new_ref;
            wb_mod         <= grant && new_mod;
            ifault         <= trap_go && req_fetch;
            dfault         <= trap_go && !req_fetch;
        end
    end

    p_one_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ifault && dfault));
    p_trap_has_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ifault || dfault) |-> (rsp_valid && rsp_fault_code != 4'd0));
    p_wb_only_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (rsp_valid && rsp_fault_code == 4'd0 && wb_ref));
    p_write_needs_mod_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rights[RIGHT_W] |-> wb_mod);
    p_far_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_fault_code != 4'd0) |-> $stable(far));
    p_fsr_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault_code != 4'd0) |-> fsr[1]);
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_fault_code == 4'd0 && rsp_rights == 3'd0 && !wb_req));
endmodule

// File: tb/pte_access_guard_tb_top.sv
module pte_access_guard_tb_top;
    localparam int VA_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_ref = 0, req_mod = 0, req_write = 0, req_fetch = 0, req_super = 0;
    logic [2:0] req_perm = 0;
    logic [VA_W-1:0] req_va = 0;
    logic nofault_mode = 0, traps_on = 0, fsr_rd = 0;
    logic rsp_valid, wb_req, wb_ref, wb_mod, ifault, dfault;
    logic [3:0] rsp_fault_code;
    logic [2:0] rsp_rights;
    logic [7:0] fsr;
    logic [VA_W-1:0] far;

    pte_access_guard #(.VA_W(VA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_perm(req_perm),
        .req_ref(req_ref), .req_mod(req_mod), .req_write(req_write),
        .req_fetch(req_fetch), .req_super(req_super), .req_va(req_va),
        .nofault_mode(nofault_mode), .traps_on(traps_on), .fsr_rd(fsr_rd),
        .rsp_valid(rsp_valid), .rsp_fault_code(rsp_fault_code),
        .rsp_rights(rsp_rights), .wb_req(wb_req), .wb_ref(wb_ref),
        .wb_mod(wb_mod), .ifault(ifault), .dfault(dfault), .fsr(fsr), .far(far)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model state and expectations
    logic [7:0] m_fsr = 0;
    logic [VA_W-1:0] m_far = 0;
    logic e_valid, e_wb, e_wbref, e_wbmod, e_if, e_df;
    logic [3:0] e_code;
    logic [2:0] e_rights;
    logic [31:0] lcg = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] m_err(input logic [2:0] p, input logic w, input logic f, input logic s);
        logic [7:0] rm, wm, xm;
        bit ok;
        rm = s ? 8'hEF : 8'h2F;
        wm = s ? 8'hAA : 8'h0A;
        xm = s ? 8'hDC : 8'h1C;
        if (!s && p >= 3'd6) return 4'd12;
        ok = 1;
        if (w && !wm[p]) ok = 0;
        if (f && !xm[p]) ok = 0;
        if (!w && !f && !rm[p]) ok = 0;
        return ok ? 4'd0 : 4'd8;
    endfunction

    function automatic logic [2:0] m_rights(input logic [2:0] p, input logic s);
        logic [7:0] rm, wm, xm;
        rm = s ? 8'hEF : 8'h2F;
        wm = s ? 8'hAA : 8'h0A;
        xm = s ? 8'hDC : 8'h1C;
        return {xm[p], wm[p], rm[p]};
    endfunction

    task automatic compare_all();
        chk(rsp_valid === e_valid, "R12", "rsp_valid", 64'(rsp_valid), 64'(e_valid));
        chk(rsp_fault_code === e_code, "R2", "fault_code", 64'(rsp_fault_code), 64'(e_code));
        chk(rsp_rights === e_rights, "R5", "rights", 64'(rsp_rights), 64'(e_rights));
        chk({wb_req, wb_ref, wb_mod} === {e_wb, e_wbref, e_wbmod}, "R4", "writeback",
            64'({wb_req, wb_ref, wb_mod}), 64'({e_wb, e_wbref, e_wbmod}));
        chk({ifault, dfault} === {e_if, e_df}, "R9", "traps", 64'({ifault, dfault}), 64'({e_if, e_df}));
        chk(fsr === m_fsr, "R7", "fsr", 64'(fsr), 64'(m_fsr));
        chk(far === m_far, "R7", "far", 64'(far), 64'(m_far));
    endtask

    // Drive one cycle, predict, wait one clock, compare
    task automatic cyc(input logic v, input logic [2:0] p, input logic rf, input logic md,
                       input logic w, input logic f, input logic s, input logic [VA_W-1:0] va,
                       input logic nf, input logic te, input logic rd);
        logic [3:0] err;
        logic [7:0] base;
        logic flt, ok, nmod;
        req_valid = v; req_perm = p; req_ref = rf; req_mod = md; req_write = w;
        req_fetch = f; req_super = s; req_va = va; nofault_mode = nf; traps_on = te; fsr_rd = rd;
        err  = m_err(p, w, f, s);
        flt  = v && err != 0 && !(nf && !s);
        ok   = v && !flt;
        nmod = md | w;
        base = rd ? 8'h00 : m_fsr;
        if (flt) begin
            m_fsr = (base != 0 ? 8'h01 : 8'h00) | ({5'b0, w, f, s} << 5) | {4'b0, err} | 8'h02;
            m_far = va;
        end else begin
            m_fsr = base;
        end
        e_valid  = v;
        e_code   = flt ? err : 4'd0;
        e_rights = ok ? (m_rights(p, s) & (nmod ? 3'b111 : 3'b101)) : 3'd0;
        e_wb     = ok && (!rf || (w && !md));
        e_wbref  = ok;
        e_wbmod  = ok && nmod;
        e_if     = flt && !nf && te && f;
        e_df     = flt && !nf && te && !f;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk({rsp_valid, rsp_fault_code, rsp_rights, wb_req, wb_ref, wb_mod, ifault, dfault} == 0,
            "R11", "outputs in reset", 64'({rsp_valid, rsp_fault_code, rsp_rights}), 0);
        chk(fsr == 0 && far == 0, "R11", "regs in reset", 64'(fsr), 0);
        rst_n = 1'b1;

        // R1: user load and fetch on code 6 and 7
        cyc(1, 3'd6, 1, 1, 0, 0, 0, 32'h1000, 0, 1, 1);
        chk(rsp_fault_code == 4'd12, "R1", "user code6 load", 64'(rsp_fault_code), 12);
        cyc(1, 3'd7, 1, 1, 0, 1, 0, 32'h2000, 0, 1, 1);
        chk(rsp_fault_code == 4'd12 && ifault, "R1", "user code7 fetch", 64'(rsp_fault_code), 12);

        // R6: supervisor load on code 1 with clean page gets no W; store does
        cyc(1, 3'd1, 1, 0, 0, 0, 1, 32'h3000, 0, 1, 1);
        chk(rsp_rights == 3'b001, "R6", "clean page rights", 64'(rsp_rights), 1);
        cyc(1, 3'd1, 1, 0, 1, 0, 1, 32'h3000, 0, 1, 0);
        chk(rsp_rights == 3'b011 && wb_req, "R6", "store marks modified", 64'(rsp_rights), 3);

        // R8: two faults without a read
        cyc(1, 3'd4, 1, 1, 0, 0, 1, 32'h4000, 0, 1, 1);
        cyc(1, 3'd0, 1, 1, 1, 0, 1, 32'h5000, 0, 1, 0);
        chk(fsr[0] == 1'b1 && fsr[1], "R8", "overflow mark", 64'(fsr[0]), 1);

        // R10: read clears, read with fault writes fresh
        cyc(0, 3'd0, 0, 0, 0, 0, 0, 32'h0, 0, 1, 1);
        chk(fsr == 8'h00, "R10", "read clear", 64'(fsr), 0);
        cyc(1, 3'd0, 1, 1, 1, 0, 1, 32'h6000, 0, 1, 0);
        cyc(1, 3'd0, 1, 1, 0, 1, 1, 32'h7000, 0, 1, 1);
        chk(fsr == 8'h6A, "R10", "read with fault", 64'(fsr), 64'h6A);

        // R3: user fault ignored in no-fault mode, supervisor still recorded without trap
        held = fsr;
        cyc(1, 3'd0, 1, 1, 0, 1, 0, 32'h8000, 1, 1, 0);
        chk(fsr == held && !ifault && rsp_fault_code == 0, "R3", "user fault ignored", 64'(fsr), 64'(held));
        cyc(1, 3'd4, 1, 1, 0, 0, 1, 32'h9000, 1, 1, 1);
        chk(rsp_fault_code == 8 && !dfault && far == 32'h9000, "R3", "supervisor recorded", 64'(far), 64'h9000);

        // R9: traps disabled
        cyc(1, 3'd0, 1, 1, 1, 0, 1, 32'hA000, 0, 0, 1);
        chk(!dfault && rsp_fault_code == 8, "R9", "traps off", 64'(dfault), 0);

        // Sweep every kind, privilege, code and ref/mod state
        for (int k = 0; k < 4; k++)
            for (int s = 0; s < 2; s++)
                for (int p = 0; p < 8; p++)
                    for (int rm = 0; rm < 4; rm++)
                        cyc(1, 3'(p), rm[1], rm[0], k[1], k[0], s[0],
                            32'(k * 4096 + p * 16 + rm), 0, 1, (p == 5));

        // Pseudo-random mix including idle cycles and mode changes
        for (int i = 0; i < 600; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            cyc(lcg[31] | lcg[30], lcg[2:0], lcg[3], lcg[4], lcg[5], lcg[6], lcg[7],
                {lcg[27:8], 12'h0}, lcg[28] & lcg[29], lcg[9] | lcg[10], lcg[11] & lcg[12]);
        end

        cyc(0, 3'd0, 0, 0, 0, 0, 0, 32'h0, 0, 1, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule